// File: doc/BRIEF.md
# Per-Line Event Interrupt Bank

This block turns a bank of synchronized input lines into one interrupt request. Each line carries its own 3-bit detection code. The code chooses one of five conditions: a high-to-low transition, a low-to-high transition, any transition, a low level or a high level. A line that meets its condition sets a bit in a pending-event register. That register empties itself when software reads it.

A separate enable register decides which pending bits may raise the shared interrupt output. Software sets bits in it through one write address and clears bits through another, so a read-modify-write is never needed. Events are recorded whether or not their line is enabled. Enabling a line later therefore exposes an event that is already pending.

The bus is a simple single-cycle register port. A write takes effect at the clock edge that samples it. Read data is returned combinationally in the same cycle. A read of the pending register clears it at that same edge.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the pending register and the enable register are all zero and `irq_out` is low.
- R2: Code 0 on a line sets that line's pending bit at the clock edge where the line is sampled low after having been sampled high on the previous edge.
- R3: Code 1 sets the pending bit on a sampled low-to-high transition.
- R4: Code 2 sets the pending bit on a sampled transition in either direction.
- R5: Code 3 sets the pending bit on every edge at which the line is sampled low. The bit therefore reappears after a read for as long as the level persists.
- R6: Code 4 sets the pending bit on every edge at which the line is sampled high.
- R7: Codes 5, 6 and 7 never set a pending bit, whatever the line does.
- R8: A write to offset 0x20 sets the enable bits where the write data has ones. A write to 0x24 clears them. Enable bits at zero positions are left unchanged. A read of 0x28 returns the enable register. A read of any other offset except 0x2C returns zero.
- R9: A read of offset 0x2C returns the pending register and clears it at the same edge. An event detected at that same edge is still recorded and appears in the next read.
- R10: Pending bits are recorded regardless of the enable register.
- R11: `irq_out` is high exactly when some bit is set in both the pending register and the enable register.
- R12: At the first clock edge after reset is released, no transition is detected, because there is no previous sample yet. Level conditions do apply at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_lvl | input | NLINES | Synchronized line levels |
| evsel | input | NLINES*3 | Per-line detection codes; line i uses bits [3i+2:3i] |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset |
| bus_wdata | input | NLINES | Write data |
| bus_rdata | output | NLINES | Read data; zero when no read is in progress |
| irq_out | output | 1 | Bank interrupt request |

## Verification
The risky overlap is a read of the pending register at the same edge at which a line meets its condition. The clear must not swallow that new event.

The bench provokes this overlap by raising a high-level line in the same cycle that it issues the read. It then expects that read to return zero and the following read to return the new bit.

A low-level line held through consecutive reads exercises the same overlap on every read. A cycle-by-cycle reference model, compared on each clock, judges both the read data and the interrupt output throughout the run.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    EV_FALL = 3'd0,
    EV_RISE = 3'd1,
    EV_BOTH = 3'd2,
    EV_LOW  = 3'd3,
    EV_HIGH = 3'd4
  } ev_sel_e;
endpackage

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NLINES = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NLINES-1:0]       line_lvl,
  input  logic [NLINES*SEL_W-1:0] evsel,
  output logic [NLINES-1:0]       hit
);
  logic [NLINES-1:0] prev_q, prev_d;
  logic              primed_q, primed_d;

  // Next state: remember the current sample; edge detection is armed after one edge.
  always_comb begin
    prev_d   = line_lvl;
    primed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= prev_d;
      primed_q <= primed_d;
    end
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic [SEL_W-1:0] sel;
    logic             rise, fall, hit_l;

    assign sel  = evsel[i*SEL_W +: SEL_W];
    assign rise = primed_q &  line_lvl[i] & ~prev_q[i];
    assign fall = primed_q & ~line_lvl[i] &  prev_q[i];

    always_comb begin
      case (sel)
        EV_FALL: hit_l = fall;
        EV_RISE: hit_l = rise;
        EV_BOTH: hit_l = rise | fall;
        EV_LOW:  hit_l = ~line_lvl[i];
        EV_HIGH: hit_l =  line_lvl[i];
        default: hit_l = 1'b0;
      endcase
    end

    assign hit[i] = hit_l;

    // R7: unused codes stay silent
    a_r7_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (sel > 3'd4) |-> !hit[i]);
    // R6: a high line under code 4 always reports
    a_r6_high_level: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == 3'd4 && line_lvl[i]) |-> hit[i]);
    // R5: a low line under code 3 always reports
    a_r5_low_level: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == 3'd3 && !line_lvl[i]) |-> hit[i]);
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs #(
  parameter int          NLINES  = 32,
  parameter int          AW      = 8,
  parameter logic [7:0]  OFS_ENA = 8'h20,
  parameter logic [7:0]  OFS_DIS = 8'h24,
  parameter logic [7:0]  OFS_MSK = 8'h28,
  parameter logic [7:0]  OFS_PND = 8'h2C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] hit,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [NLINES-1:0] bus_wdata,
  output logic [NLINES-1:0] bus_rdata,
  output logic [NLINES-1:0] mask_q,
  output logic [NLINES-1:0] stat_q
);
  localparam logic [AW-1:0] A_ENA = AW'(OFS_ENA);
  localparam logic [AW-1:0] A_DIS = AW'(OFS_DIS);
  localparam logic [AW-1:0] A_MSK = AW'(OFS_MSK);
  localparam logic [AW-1:0] A_PND = AW'(OFS_PND);

  logic              wr_ena, wr_dis, rd_any, rd_stat;
  logic              mask_en, stat_en;
  logic [NLINES-1:0] mask_d, stat_d;

  assign wr_ena  = bus_sel &  bus_wr & (bus_addr == A_ENA);
  assign wr_dis  = bus_sel &  bus_wr & (bus_addr == A_DIS);
  assign rd_any  = bus_sel & ~bus_wr;
  assign rd_stat = rd_any & (bus_addr == A_PND);

  // Next state
  always_comb begin
    mask_en = wr_ena | wr_dis;
    mask_d  = mask_q;
    if (wr_ena) mask_d = mask_d |  bus_wdata;
    if (wr_dis) mask_d = mask_d & ~bus_wdata;

    stat_en = rd_stat | (|hit);
    stat_d  = (rd_stat ? '0 : stat_q) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (mask_en) mask_q <= mask_d;
      if (stat_en) stat_q <= stat_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_any) begin
      if (bus_addr == A_MSK)      bus_rdata = mask_q;
      else if (bus_addr == A_PND) bus_rdata = stat_q;
    end
  end

  a_r8_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ena |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));
  a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dis |=> ((mask_q & $past(bus_wdata)) == '0));
  a_r9_read_keeps_new: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> (stat_q == $past(hit)));
  a_r9_sticky_unread: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  a_r10_latch_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((stat_q & $past(hit)) == $past(hit)));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int AW     = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NLINES-1:0]       line_lvl,
  input  logic [NLINES*SEL_W-1:0] evsel,
  input  logic                    bus_sel,
  input  logic                    bus_wr,
  input  logic [AW-1:0]           bus_addr,
  input  logic [NLINES-1:0]       bus_wdata,
  output logic [NLINES-1:0]       bus_rdata,
  output logic                    irq_out
);
  logic [NLINES-1:0] hit, mask_q, stat_q;

  gpio_irq_detect #(.NLINES(NLINES)) i_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_lvl (line_lvl),
    .evsel    (evsel),
    .hit      (hit)
  );

  gpio_irq_regs #(.NLINES(NLINES), .AW(AW)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (hit),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .mask_q    (mask_q),
    .stat_q    (stat_q)
  );

  assign irq_out = |(stat_q & mask_q);

  // R11: a request needs at least one enabled line
  a_r11_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (mask_q != '0));
  // R11: a request needs at least one pending line
  a_r11_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (stat_q != '0));
endmodule

// File: tb/test_gpio_irq_bank.sv
`timescale 1ns/1ps
module test_gpio_irq_bank;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  lvl;
  logic [2:0]    code [N];
  logic [N*3-1:0] evsel;
  logic          sel, wr;
  logic [7:0]    addr;
  logic [N-1:0]  wdata, rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) evsel[i*3 +: 3] = code[i];

  gpio_irq_bank i_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .line_lvl(lvl), .evsel(evsel),
    .bus_sel(sel), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .irq_out(irq)
  );

  // Behavioural reference model
  logic [N-1:0] m_mask, m_stat, m_prev;
  bit           m_primed;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mask = '0; m_stat = '0; m_prev = '0; m_primed = 0;
    end else begin
      logic [N-1:0] h;
      h = '0;
      for (int i = 0; i < N; i++) begin
        bit r, f;
        r = m_primed && lvl[i] && !m_prev[i];
        f = m_primed && !lvl[i] && m_prev[i];
        if (code[i] == 0 && f) h[i] = 1;
        if (code[i] == 1 && r) h[i] = 1;
        if (code[i] == 2 && (r || f)) h[i] = 1;
        if (code[i] == 3 && !lvl[i]) h[i] = 1;
        if (code[i] == 4 && lvl[i]) h[i] = 1;
      end
      if (sel && !wr && addr == 8'h2C) m_stat = '0;
      m_stat = m_stat | h;
      if (sel && wr && addr == 8'h20) m_mask = m_mask | wdata;
      if (sel && wr && addr == 8'h24) m_mask = m_mask & ~wdata;
      m_prev = lvl; m_primed = 1;
    end
  end

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [N-1:0] er;
      er = '0;
      if (sel && !wr && addr == 8'h28) er = m_mask;
      if (sel && !wr && addr == 8'h2C) er = m_stat;
      check("R11 model irq", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, |(m_stat & m_mask)});
      check("R8/R9 model rdata", rdata, er);
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic rd(input logic [7:0] a, input logic [N-1:0] exp, input string tag);
    sel = 1; wr = 0; addr = a;
    @(negedge clk);
    check(tag, rdata, exp);
    step();
    sel = 0;
  endtask

  task automatic wrr(input logic [7:0] a, input logic [N-1:0] d);
    sel = 1; wr = 1; addr = a; wdata = d;
    step();
    sel = 0; wr = 0; wdata = '0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    check(tag, {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, e});
    step();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; sel = 0; wr = 0; addr = '0; wdata = '0;
    for (int i = 0; i < N; i++) code[i] = 3'd7;
    code[0] = 3'd1; code[1] = 3'd1; code[2] = 3'd0; code[3] = 3'd2;
    code[4] = 3'd3; code[5] = 3'd4; code[6] = 3'd5; code[7] = 3'd6; code[8] = 3'd7;
    lvl = 32'h0000_0011;  // line 0 high (R12 probe), line 4 idle high
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset state, R12 line 0 high at release gives no rising event
    chk_irq(1'b0, "R1 irq");
    rd(8'h28, '0, "R1 mask");
    rd(8'h2C, '0, "R12 no edge at release");
    // R3 rising
    lvl[1] = 1; step(); step();
    rd(8'h2C, 32'h2, "R3 rise");
    rd(8'h2C, '0, "R9 cleared");
    // R2 falling: rise ignored, fall reported
    lvl[2] = 1; step(); step();
    rd(8'h2C, '0, "R2 rise ignored");
    lvl[2] = 0; step();
    rd(8'h2C, 32'h4, "R2 fall");
    // R4 both
    lvl[3] = 1; step();
    rd(8'h2C, 32'h8, "R4 up");
    lvl[3] = 0; step();
    rd(8'h2C, 32'h8, "R4 down");
    // R5 low level persists through reads
    lvl[4] = 0; step(); step();
    rd(8'h2C, 32'h10, "R5 low");
    rd(8'h2C, 32'h10, "R5 reappears");
    lvl[4] = 1; step();
    rd(8'h2C, 32'h10, "R5 last event kept");
    rd(8'h2C, '0, "R5 gone");
    // R6 high level
    lvl[5] = 1; step(); lvl[5] = 0; step();
    rd(8'h2C, 32'h20, "R6 high");
    rd(8'h2C, '0, "R6 gone");
    // R7 reserved codes
    for (int k = 0; k < 4; k++) begin lvl[8:6] = ~lvl[8:6]; step(); end
    rd(8'h2C, '0, "R7 reserved silent");
    // R8 enable/disable/mask
    wrr(8'h20, 32'hF0);
    rd(8'h28, 32'hF0, "R8 enable");
    wrr(8'h20, 32'h03);
    rd(8'h28, 32'hF3, "R8 enable merge");
    wrr(8'h24, 32'h30);
    rd(8'h28, 32'hC3, "R8 disable");
    rd(8'h10, '0, "R8 other offset");
    // R10 / R11: unmasked line 4 latches without irq
    lvl[4] = 0; step(); lvl[4] = 1; step();
    chk_irq(1'b0, "R11 masked no irq");
    rd(8'h2C, 32'h10, "R10 latched while masked");
    // R11: enabled line 1 raises irq
    lvl[1] = 0; step(); lvl[1] = 1; step();
    chk_irq(1'b1, "R11 irq high");
    rd(8'h2C, 32'h2, "R11 pending");
    chk_irq(1'b0, "R11 irq low after read");
    // R9 event in the same cycle as the read
    lvl[5] = 1;
    rd(8'h2C, '0, "R9 read during event");
    lvl[5] = 0; step();
    rd(8'h2C, 32'h20, "R9 event kept");
    step();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule